// File: doc/BRIEF.md
# Variable Length Pattern Bus Encoder

This block sits in front of a wide off-chip data bus and cuts switching activity by replacing repeated high-order bit patterns with a short code. Each valid input word is looked up in several associative segments. Each segment holds patterns of one width, taken from the top of the word: by default 32, 24 and 16 bits. When a lookup hits, the matched high-order portion is replaced by an 8-bit code placed in the top bits. The unmatched low-order bits travel unchanged underneath. A single flag tells the far end that the word carries a code.

If no segment matches, the word is sent as it is. Its three prefixes are then written into their segments, each at that segment's own round-robin slot. Hits never modify the table. Because of this, a receiver that applies the same insertion rule to every uncoded word keeps an identical copy of the table. Results appear one clock after the word is presented.

Top module: `vlpe_bus_encoder`

## Requirements
- R1: After reset `out_valid` and `out_coded` are 0 and every segment is empty, so the first word presented afterwards comes out uncoded.
- R2: Each word accepted with `in_valid` high produces exactly one result with `out_valid` high on the following clock edge.
- R3: On a miss in every segment, `out_word` equals the input word and `out_coded` is 0. The word's 32-, 24- and 16-bit high-order prefixes are each stored in their segment.
- R4: A full 32-bit hit produces `{code, 24'h000000}` with `out_coded` = 1.
- R5: A 24-bit prefix hit without a 32-bit hit produces `{code, 16'h0000, word[7:0]}`.
- R6: A hit on the 16-bit prefix only produces `{code, 8'h00, word[15:0]}`.
- R7: When several segments hit, the segment with the widest pattern supplies the code.
- R8: The code is 8 bits wide. Bits [7:6] hold the segment number (1 = 32-bit, 2 = 24-bit, 3 = 16-bit). Bits [5:0] hold the slot index where the matched pattern was stored.
- R9: Each segment has 8 slots, filled in the order 0 to 7 by successive misses. The ninth miss overwrites slot 0, so the oldest pattern is evicted.
- R10: A hit leaves the table and the replacement slots unchanged. The next miss therefore goes to the slot that follows the previous miss.
- R11: A cycle with `in_valid` low gives `out_valid` = 0 and `out_coded` = 0 one clock later, and writes nothing into the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word qualifier |
| in_word | input | 32 | Word to be encoded |
| out_valid | output | 1 | Result qualifier, one clock after input |
| out_coded | output | 1 | High when `out_word` carries a code in its top bits |
| out_word | output | 32 | Word to drive onto the bus |

## Verification
Every result is due exactly one rising edge after its word. The lookup reads the table registers combinationally, and the output register is the only stage on the way. A word presented at a falling edge is therefore checked at the next falling edge. Table writes land on that same edge, so a word's effect on the table is visible to the very next word, and the directed sequences depend on this. Idle cycles are checked the same way: one falling edge after `in_valid` drops. A later word then confirms that nothing was inserted during the idle cycle.

// File: rtl/vlpe_pkg.sv
package vlpe_pkg;
    localparam int unsigned DEF_DATA_W  = 32;
    localparam int unsigned DEF_CODE_W  = 8;
    localparam int unsigned DEF_SEGS    = 3;
    localparam int unsigned DEF_STEP    = 8;
    localparam int unsigned DEF_ENTRIES = 8;

    // pattern width held by segment s (s = 0 is the widest)
    function automatic int unsigned seg_width(int unsigned data_w, int unsigned step, int unsigned s);
        return data_w - s * step;
    endfunction
endpackage

// File: rtl/vlpe_seg_cam.sv
module vlpe_seg_cam #(
    parameter int unsigned PAT_W   = 32,
    parameter int unsigned ENTRIES = 8,
    localparam int unsigned PTR_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PAT_W-1:0] key,
    input  logic             ins_en,
    output logic             hit,
    output logic [PTR_W-1:0] hit_idx
);
    typedef struct packed {
        logic [ENTRIES-1:0]            vld;
        logic [ENTRIES-1:0][PAT_W-1:0] pat;
        logic [PTR_W-1:0]              ptr;
    } cam_t;

    cam_t st_d, st_q;
    logic [ENTRIES-1:0] match;

    always_comb begin
        st_d    = st_q;
        hit     = 1'b0;
        hit_idx = '0;
        // descending scan: lowest matching slot is assigned last
        for (int e = ENTRIES - 1; e >= 0; e--) begin
            match[e] = st_q.vld[e] && (st_q.pat[e] == key);
            if (match[e]) begin
                hit     = 1'b1;
                hit_idx = PTR_W'(e);
            end
        end
        if (ins_en) begin
            st_d.pat[st_q.ptr] = key;
            st_d.vld[st_q.ptr] = 1'b1;
            st_d.ptr = (st_q.ptr == PTR_W'(ENTRIES - 1)) ? '0 : st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/vlpe_pick.sv
module vlpe_pick #(
    parameter int unsigned SEGS  = 3,
    parameter int unsigned PTR_W = 3,
    localparam int unsigned SEL_W = (SEGS > 1) ? $clog2(SEGS) : 1
) (
    input  logic [SEGS-1:0]            seg_hit,
    input  logic [SEGS-1:0][PTR_W-1:0] seg_idx,
    output logic                       any_hit,
    output logic [SEL_W-1:0]           win_seg,
    output logic [PTR_W-1:0]           win_idx
);
    always_comb begin
        any_hit = |seg_hit;
        win_seg = '0;
        win_idx = '0;
        // segment 0 is widest; scan downward so it wins last
        for (int s = SEGS - 1; s >= 0; s--) begin
            if (seg_hit[s]) begin
                win_seg = SEL_W'(s);
                win_idx = seg_idx[s];
            end
        end
    end
endmodule

// File: rtl/vlpe_bus_encoder.sv
module vlpe_bus_encoder #(
    parameter int unsigned DATA_W  = vlpe_pkg::DEF_DATA_W,
    parameter int unsigned CODE_W  = vlpe_pkg::DEF_CODE_W,
    parameter int unsigned SEGS    = vlpe_pkg::DEF_SEGS,
    parameter int unsigned STEP    = vlpe_pkg::DEF_STEP,
    parameter int unsigned ENTRIES = vlpe_pkg::DEF_ENTRIES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_word,
    output logic              out_valid,
    output logic              out_coded,
    output logic [DATA_W-1:0] out_word
);
    localparam int unsigned PTR_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int unsigned SEL_W    = (SEGS > 1) ? $clog2(SEGS) : 1;
    localparam int unsigned SEGNUM_W = $clog2(SEGS + 1);
    localparam int unsigned IDX_W    = CODE_W - SEGNUM_W;
    localparam int unsigned LOW_W    = DATA_W - CODE_W;

    typedef struct packed {
        logic              vld;
        logic              coded;
        logic [DATA_W-1:0] word;
    } out_t;

    out_t o_d, o_q;

    logic [SEGS-1:0]              seg_hit;
    logic [SEGS-1:0][PTR_W-1:0]   seg_idx;
    logic [SEGS-1:0][DATA_W-1:0]  seg_mask;
    logic                         any_hit;
    logic [SEL_W-1:0]             win_seg;
    logic [PTR_W-1:0]             win_idx;
    logic                         ins_en;
    logic [CODE_W-1:0]            code;

    assign ins_en = in_valid && !any_hit;

    for (genvar s = 0; s < SEGS; s++) begin : g_seg
        localparam int unsigned PW = vlpe_pkg::seg_width(DATA_W, STEP, s);
        assign seg_mask[s] = ~({DATA_W{1'b1}} >> PW);
        vlpe_seg_cam #(
            .PAT_W  (PW),
            .ENTRIES(ENTRIES)
        ) u_cam (
            .clk    (clk),
            .rst_n  (rst_n),
            .key    (in_word[DATA_W-1 -: PW]),
            .ins_en (ins_en),
            .hit    (seg_hit[s]),
            .hit_idx(seg_idx[s])
        );
    end

    vlpe_pick #(
        .SEGS (SEGS),
        .PTR_W(PTR_W)
    ) u_pick (
        .seg_hit(seg_hit),
        .seg_idx(seg_idx),
        .any_hit(any_hit),
        .win_seg(win_seg),
        .win_idx(win_idx)
    );

    always_comb begin
        o_d       = o_q;
        code      = {SEGNUM_W'(win_seg) + SEGNUM_W'(1), IDX_W'(win_idx)};
        o_d.vld   = in_valid;
        o_d.coded = in_valid && any_hit;
        if (in_valid) begin
            if (any_hit) o_d.word = {code, {LOW_W{1'b0}}} | (in_word & ~seg_mask[win_seg]);
            else         o_d.word = in_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign out_valid = o_q.vld;
    assign out_coded = o_q.coded;
    assign out_word  = o_q.word;
endmodule

// File: rtl/vlpe_bus_encoder_chk.sv
module vlpe_bus_encoder_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CODE_W = 8,
    parameter int unsigned STEP   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_word,
    input logic              out_valid,
    input logic              out_coded,
    input logic [DATA_W-1:0] out_word
);
    logic [1:0] segf;
    assign segf = out_word[DATA_W-1 -: 2];

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_coded));
    // R3
    raw_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_coded) |-> out_word == $past(in_word));
    // R8
    seg_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_coded |-> segf != 2'd0);
    // R4
    full_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_coded && segf == 2'd1) |-> out_word[DATA_W-CODE_W-1:0] == '0);
    // R5
    mid_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_coded && segf == 2'd2) |-> out_word[STEP-1:0] == $past(in_word[STEP-1:0]));
    // R6
    short_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_coded && segf == 2'd3) |-> out_word[2*STEP-1:0] == $past(in_word[2*STEP-1:0]));
    // R10
    repeat_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && $past(in_valid) && in_word == $past(in_word)) |=> out_coded);
endmodule

bind vlpe_bus_encoder vlpe_bus_encoder_chk #(
    .DATA_W(DATA_W),
    .CODE_W(CODE_W),
    .STEP  (STEP)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_word  (in_word),
    .out_valid(out_valid),
    .out_coded(out_coded),
    .out_word (out_word)
);

// File: tb/vlpe_bus_encoder_test.sv
`timescale 1ns/1ps
module vlpe_bus_encoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        out_valid, out_coded;
    logic [31:0] out_word;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    vlpe_bus_encoder uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .out_valid(out_valid), .out_coded(out_coded), .out_word(out_word)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // present one word at a falling edge, check the result one edge later
    task automatic send(input logic [31:0] w, input logic [31:0] ew, input logic ec, input string tag);
        in_valid = 1'b1;
        in_word  = w;
        @(negedge clk);
        check({31'd0, out_valid}, 32'd1, "R2 out_valid");
        check({31'd0, out_coded}, {31'd0, ec}, tag);
        check(out_word, ew, tag);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check({31'd0, out_valid}, 32'd0, "R1 out_valid after reset");
        check({31'd0, out_coded}, 32'd0, "R1 out_coded after reset");
        send(32'h12345678, 32'h12345678, 1'b0, "R1 R3 first word raw");
    endtask

    task automatic t_widths();
        send(32'h12345678, 32'h40000000, 1'b1, "R4 R8 full hit slot0");
        send(32'h123456AB, 32'h800000AB, 1'b1, "R5 24-bit hit");
        send(32'h1234FFFF, 32'hC000FFFF, 1'b1, "R6 16-bit hit");
    endtask

    task automatic t_priority();
        send(32'hAABBCCDD, 32'hAABBCCDD, 1'b0, "R3 miss raw");
        send(32'hAABBCCDD, 32'h41000000, 1'b1, "R7 R8 widest wins slot1");
        send(32'hAABBCC01, 32'h81000001, 1'b1, "R7 24 over 16");
    endtask

    task automatic t_hit_static();
        send(32'h55667788, 32'h55667788, 1'b0, "R10 miss after hits");
        send(32'h55667788, 32'h42000000, 1'b1, "R10 slot2 after hits");
        send(32'h556677EE, 32'h820000EE, 1'b1, "R10 R5 slot2 24-bit");
    endtask

    task automatic t_wrap();
        for (int k = 1; k <= 5; k++)
            send({8'h60 + 8'(k), 24'h0}, {8'h60 + 8'(k), 24'h0}, 1'b0, "R9 fill");
        send(32'h66000000, 32'h66000000, 1'b0, "R9 ninth miss");
        send(32'h66000000, 32'h40000000, 1'b1, "R9 wrapped to slot0");
        send(32'h12345678, 32'h12345678, 1'b0, "R9 oldest evicted");
        send(32'h61000000, 32'h43000000, 1'b1, "R9 slot3 kept");
    endtask

    task automatic t_idle();
        in_valid = 1'b0;
        in_word  = 32'h77778888;
        @(negedge clk);
        check({31'd0, out_valid}, 32'd0, "R11 out_valid idle");
        check({31'd0, out_coded}, 32'd0, "R11 out_coded idle");
        send(32'h77778888, 32'h77778888, 1'b0, "R11 idle word not stored");
        send(32'h77778888, 32'h42000000, 1'b1, "R11 stored after valid");
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_widths();
        t_priority();
        t_hit_static();
        t_wrap();
        t_idle();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule